// File: doc/BRIEF.md
# Carry-Instruction Flag Unit

This block holds the flag byte of an 8-bit accumulator processor, together with a hidden 8-bit latch. The latch records the flag value that the most recent instruction produced, if that instruction wrote the flags. Once per clock the block accepts the class of the retiring instruction, a candidate flag byte and the current accumulator value. It then updates the flag byte and the latch at the clock edge.

The latch matters only for the set-carry and complement-carry instructions. Those two instructions rebuild the two undocumented flag bits, bit 5 and bit 3. When either of them directly follows an instruction that wrote the flags, the latch equals F, and the two bits are copied from the accumulator. When either follows an instruction that left the flags alone, or a direct load of F, the latch is zero, and the two bits become the OR of their old F values and the accumulator.

Flag layout used throughout: bit 7 sign, bit 6 zero, bit 5 undocumented, bit 4 half-carry, bit 3 undocumented, bit 2 parity/overflow, bit 1 subtract, bit 0 carry. Instruction class codes on `op_i`: 0 = flags untouched, 1 = flag-writing operation, 2 = direct load of F, 3 = set carry, 4 = complement carry, 5 to 7 = unused.

Top module: `carry_flag_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `flags_o` and `q_o` are both 0x00.
- R2: Class 1 (flag-writing operation) loads `fin_i` into both `flags_o` and `q_o` at the next clock edge.
- R3: Class 0 (flags untouched) leaves `flags_o` unchanged and clears `q_o` to 0x00.
- R4: Class 2 (direct load of F) loads `fin_i` into `flags_o` and clears `q_o` to 0x00.
- R5: Class 3 (set carry) sets bit 0 to 1, clears bits 4 and 1, keeps bits 7, 6 and 2, and loads the resulting flag byte into `q_o`.
- R6: Class 4 (complement carry) sets bit 4 to the old bit 0, inverts bit 0, clears bit 1, keeps bits 7, 6 and 2, and loads the resulting flag byte into `q_o`.
- R7: For classes 3 and 4, new bits 5 and 3 equal ((Q xor F) or A) masked to 0x28. This gives a copy of A when the previous instruction wrote the flags (class 1, 3 or 4). It gives the OR of old F and A after class 0 or class 2.
- R8: For classes 3 and 4, accumulator bits other than 5 and 3 have no effect on `flags_o`.
- R9: Unused classes 5 to 7 behave as class 0: F is unchanged, `q_o` is cleared and `fin_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Class of the retiring instruction |
| fin_i | input | 8 | Flag byte from the ALU, or the value for a direct load |
| acc_i | input | 8 | Current accumulator value |
| flags_o | output | 8 | Flag register F |
| q_o | output | 8 | Hidden latch Q |

## Verification
The bench goes after the sequences that separate move from OR:
- a flag write followed directly by set carry;
- a flag write, one untouched instruction, then set carry;
- a direct load of F followed by set or complement carry;
- back-to-back set and complement carries.

A design that never clears the latch would give a move where an OR belongs. A design that treats a direct load as a flag write would wrongly copy A after the load. Accumulator values with every bit set except bits 5 and 3 expose any leak of other bits into the result. A flag byte with sign, zero and parity set shows whether those bits survive the carry instructions. Unused class codes carrying a nonzero `fin_i` reveal a design that loads F on them.

// File: rtl/cfu_pkg.sv
// Package for the carry-instruction flag unit: instruction class codes
// and flag bit positions shared by the RTL and the checker.
package cfu_pkg;
    localparam int unsigned FLAG_W  = 8;
    localparam int unsigned CLASS_W = 3;

    localparam int unsigned BIT_S  = 7;
    localparam int unsigned BIT_Z  = 6;
    localparam int unsigned BIT_U5 = 5;
    localparam int unsigned BIT_H  = 4;
    localparam int unsigned BIT_U3 = 3;
    localparam int unsigned BIT_PV = 2;
    localparam int unsigned BIT_N  = 1;
    localparam int unsigned BIT_C  = 0;

    localparam logic [FLAG_W-1:0] UNDOC_MASK = FLAG_W'((1 << BIT_U5) | (1 << BIT_U3));
    localparam logic [FLAG_W-1:0] KEEP_MASK  =
        FLAG_W'((1 << BIT_S) | (1 << BIT_Z) | (1 << BIT_PV));

    typedef enum logic [CLASS_W-1:0] {
        CL_KEEP  = 3'd0,
        CL_ALU   = 3'd1,
        CL_LOADF = 3'd2,
        CL_SETC  = 3'd3,
        CL_CPLC  = 3'd4
    } op_class_e;
endpackage

// File: rtl/cfu_carry_logic.sv
// Combinational result of the set-carry and complement-carry instructions.
// Assumes the F and Q values presented are the registered current values.
module cfu_carry_logic
    import cfu_pkg::*;
(
    input  logic              is_cpl_i,
    input  logic [FLAG_W-1:0] f_i,
    input  logic [FLAG_W-1:0] q_i,
    input  logic [FLAG_W-1:0] acc_i,
    output logic [FLAG_W-1:0] res_o
);
    logic [FLAG_W-1:0] undoc;

    // Build bits 5/3 from the latch, old F and A, then set the carry group.
    always_comb begin
        undoc = ((q_i ^ f_i) | acc_i) & UNDOC_MASK;
        res_o = (f_i & KEEP_MASK) | undoc;
        res_o[BIT_N] = 1'b0;
        if (is_cpl_i) begin
            res_o[BIT_H] = f_i[BIT_C];
            res_o[BIT_C] = ~f_i[BIT_C];
        end else begin
            res_o[BIT_H] = 1'b0;
            res_o[BIT_C] = 1'b1;
        end
    end
endmodule

// File: rtl/cfu_state_reg.sv
// Plain W-bit state register with synchronous active-low reset to zero.
module cfu_state_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // Capture the next value every cycle, or clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= d_i;
    end
endmodule

// File: rtl/carry_flag_unit.sv
// Flag register plus hidden latch Q. Every cycle one instruction class
// retires. Flag writers load Q with their result. All other classes clear Q.
// Assumes op_i, fin_i and acc_i are valid in every cycle with rst_n high.
module carry_flag_unit
    import cfu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CLASS_W-1:0] op_i,
    input  logic [FLAG_W-1:0]  fin_i,
    input  logic [FLAG_W-1:0]  acc_i,
    output logic [FLAG_W-1:0]  flags_o,
    output logic [FLAG_W-1:0]  q_o
);
    logic [FLAG_W-1:0] carry_res;
    logic [FLAG_W-1:0] f_next;
    logic [FLAG_W-1:0] q_next;

    cfu_carry_logic u_carry (
        .is_cpl_i (op_i == CL_CPLC),
        .f_i      (flags_o),
        .q_i      (q_o),
        .acc_i    (acc_i),
        .res_o    (carry_res)
    );

    // Select next F and Q from the retiring instruction class.
    always_comb begin
        f_next = flags_o;
        q_next = '0;
        case (op_i)
            CL_ALU: begin
                f_next = fin_i;
                q_next = fin_i;
            end
            CL_LOADF: f_next = fin_i;
            CL_SETC, CL_CPLC: begin
                f_next = carry_res;
                q_next = carry_res;
            end
            default: ;
        endcase
    end

    cfu_state_reg #(.W(FLAG_W)) u_freg (
        .clk (clk), .rst_n (rst_n), .d_i (f_next), .q_o (flags_o)
    );

    cfu_state_reg #(.W(FLAG_W)) u_qreg (
        .clk (clk), .rst_n (rst_n), .d_i (q_next), .q_o (q_o)
    );
endmodule

// File: rtl/cfu_checker.sv
// Assertion checker for carry_flag_unit, attached with bind below.
module cfu_checker
    import cfu_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [CLASS_W-1:0] op_i,
    input logic [FLAG_W-1:0]  fin_i,
    input logic [FLAG_W-1:0]  acc_i,
    input logic [FLAG_W-1:0]  flags_o,
    input logic [FLAG_W-1:0]  q_o
);
    logic is_carry;
    logic is_idle;
    assign is_carry = (op_i == CL_SETC) || (op_i == CL_CPLC);
    assign is_idle  = (op_i == CL_KEEP) || (op_i > CL_CPLC);

    // R1: a reset cycle leaves both registers at zero
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (flags_o == '0) && (q_o == '0));

    a_r2_alu_load: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == CL_ALU |=> (flags_o == $past(fin_i)) && (q_o == $past(fin_i)));

    // R3 and R9: untouched or unused classes hold F and clear Q
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        is_idle |=> $stable(flags_o) && (q_o == '0));

    a_r4_loadf: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == CL_LOADF |=> (flags_o == $past(fin_i)) && (q_o == '0));

    a_r5_setc_bits: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == CL_SETC |=> flags_o[BIT_C] && !flags_o[BIT_H] && !flags_o[BIT_N]
            && ((flags_o & KEEP_MASK) == ($past(flags_o) & KEEP_MASK)));

    a_r6_cplc_bits: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == CL_CPLC |=> (flags_o[BIT_C] != $past(flags_o[BIT_C]))
            && (flags_o[BIT_H] == $past(flags_o[BIT_C])) && !flags_o[BIT_N]
            && ((flags_o & KEEP_MASK) == ($past(flags_o) & KEEP_MASK)));

    // R5/R6: Q tracks the flag byte produced by a carry instruction
    a_r6_carry_q: assert property (@(posedge clk) disable iff (!rst_n)
        is_carry |=> q_o == flags_o);

    // R7: latch equal to F means a pure copy from A
    a_r7_move: assert property (@(posedge clk) disable iff (!rst_n)
        is_carry && (q_o == flags_o) |=>
            (flags_o & UNDOC_MASK) == ($past(acc_i) & UNDOC_MASK));

    // R7: cleared latch means OR of old F and A
    a_r7_or: assert property (@(posedge clk) disable iff (!rst_n)
        is_carry && (q_o == '0) |=>
            (flags_o & UNDOC_MASK) == (($past(acc_i) | $past(flags_o)) & UNDOC_MASK));
endmodule

bind carry_flag_unit cfu_checker u_cfu_checker (
    .clk (clk), .rst_n (rst_n), .op_i (op_i), .fin_i (fin_i),
    .acc_i (acc_i), .flags_o (flags_o), .q_o (q_o)
);

// File: tb/carry_flag_unit_test.sv
`timescale 1ns/100ps
module carry_flag_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_i = 3'd0;
    logic [7:0] fin_i = 8'h00;
    logic [7:0] acc_i = 8'h00;
    logic [7:0] flags_o;
    logic [7:0] q_o;

    int total = 0;
    int bad = 0;
    logic [7:0] mf = 8'h00;
    logic [7:0] mq = 8'h00;

    always #2.5 clk = ~clk;

    carry_flag_unit uut (
        .clk (clk), .rst_n (rst_n), .op_i (op_i), .fin_i (fin_i),
        .acc_i (acc_i), .flags_o (flags_o), .q_o (q_o)
    );

    // Stimulus table: {class, fin, acc}
    localparam int NV = 20;
    localparam logic [18:0] VEC [NV] = '{
        {3'd1, 8'h28, 8'h00}, {3'd3, 8'h00, 8'h00}, {3'd0, 8'hFF, 8'h28},
        {3'd3, 8'h00, 8'h00}, {3'd2, 8'h28, 8'h00}, {3'd4, 8'h00, 8'h08},
        {3'd4, 8'h00, 8'h20}, {3'd3, 8'h00, 8'hFF}, {3'd1, 8'hD7, 8'h00},
        {3'd0, 8'h00, 8'h00}, {3'd4, 8'h00, 8'h00}, {3'd6, 8'hAA, 8'h00},
        {3'd3, 8'h00, 8'hD7}, {3'd2, 8'hFF, 8'h00}, {3'd3, 8'h00, 8'h00},
        {3'd3, 8'h00, 8'h00}, {3'd1, 8'h00, 8'h00}, {3'd7, 8'h55, 8'h00},
        {3'd4, 8'h00, 8'h28}, {3'd5, 8'h33, 8'h00}
    };

    // Reference model written from the requirements
    task automatic model(input logic [2:0] op, input logic [7:0] fin, input logic [7:0] acc);
        logic [7:0] n;
        logic [7:0] u;
        u = ((mq ^ mf) | acc) & 8'h28;
        case (op)
            3'd1: begin mf = fin; mq = fin; end
            3'd2: begin mf = fin; mq = 8'h00; end
            3'd3: begin n = (mf & 8'hC4) | u | 8'h01; mf = n; mq = n; end
            3'd4: begin
                n = (mf & 8'hC4) | u | (mf[0] ? 8'h10 : 8'h01);
                mf = n; mq = n;
            end
            default: mq = 8'h00;
        endcase
    endtask

    task automatic check(input string req, input logic [7:0] ef, input logic [7:0] eq);
        total++;
        if (flags_o !== ef || q_o !== eq) begin
            bad++;
            $display("FAIL %s: flags=%02h q=%02h expected flags=%02h q=%02h",
                     req, flags_o, q_o, ef, eq);
        end
    endtask

    // Drive one instruction at a falling edge, sample at the next falling edge
    task automatic step(input logic [2:0] op, input logic [7:0] fin, input logic [7:0] acc);
        op_i = op; fin_i = fin; acc_i = acc;
        model(op, fin, acc);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; op_i = 3'd0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1; mf = 8'h00; mq = 8'h00;
    endtask

    initial begin
        #200000;
        total++; bad++;
        $display("FAIL watchdog: expired, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        check("R1 reset", 8'h00, 8'h00);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][18:16], VEC[i][15:8], VEC[i][7:0]);
            check("R7 table", mf, mq);
        end

        // R2: flag writer loads F and Q
        do_reset();
        step(3'd1, 8'hA5, 8'h00);
        check("R2 alu", 8'hA5, 8'hA5);
        // R7 move: writer then set carry copies A
        step(3'd1, 8'h28, 8'h00);
        step(3'd3, 8'h00, 8'h00);
        check("R7 move", 8'h01, 8'h01);
        // R5 and R7: back-to-back set carry also moves
        step(3'd3, 8'h00, 8'h08);
        check("R5 setc twice", 8'h09, 8'h09);
        // R4 and R7: direct load then set carry gives OR
        step(3'd2, 8'h28, 8'h00);
        check("R4 loadf", 8'h28, 8'h00);
        step(3'd3, 8'h00, 8'h00);
        check("R7 or after load", 8'h29, 8'h29);
        // R3 and R7: writer, untouched, set carry gives OR
        step(3'd1, 8'h28, 8'h00);
        step(3'd0, 8'hFF, 8'h00);
        check("R3 keep", 8'h28, 8'h00);
        step(3'd3, 8'h00, 8'h08);
        check("R7 or after keep", 8'h29, 8'h29);
        // R6: complement carry after load of C5
        step(3'd2, 8'hC5, 8'h00);
        step(3'd4, 8'h00, 8'h20);
        check("R6 cplc", 8'hF4, 8'hF4);
        // R5: S Z PV preserved through set carry
        step(3'd2, 8'hFF, 8'h00);
        step(3'd3, 8'h00, 8'h00);
        check("R5 setc keep", 8'hED, 8'hED);
        // R8: other accumulator bits ignored
        step(3'd2, 8'h00, 8'h00);
        step(3'd3, 8'h00, 8'hD7);
        check("R8 acc mask", 8'h01, 8'h01);
        // R9: unused class ignores fin and clears Q
        step(3'd1, 8'h08, 8'h00);
        step(3'd5, 8'hFF, 8'h00);
        check("R9 unused", 8'h08, 8'h00);
        step(3'd3, 8'h00, 8'h00);
        check("R9 then or", 8'h09, 8'h09);
        // R1: mid-run reset clears both
        rst_n = 1'b0; op_i = 3'd1; fin_i = 8'hFF;
        @(negedge clk);
        check("R1 midrun reset", 8'h00, 8'h00);
        rst_n = 1'b1; op_i = 3'd0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule